// File: doc/BRIEF.md
# Integer Decode-Execute Stage

A purely combinational stage that takes one 32-bit instruction word and the two register read values already fetched for its first and second source fields. It decodes the operation, forms the second operand (either the second register value or an extended 16-bit immediate), and computes the result to write back. It also reports the destination register index, a write strobe and an overflow flag. Operations that the stage does not recognise are flagged and never write.

The supported set is signed add, wrapping add and wrapping subtract from the register-register format, plus signed add immediate, wrapping add immediate, signed and unsigned set-less-than immediate, OR immediate and load-upper immediate. Extension of the immediate is irregular by design. The wrapping add immediate and the unsigned compare still sign-extend. Only OR zero-extends. The "wrapping" forms differ from the signed ones only in never raising overflow. A register file outside the block consumes the write-back triple, and register 0 is never written.

Top module: `dx_exec_unit`

## Requirements
- R1: Fields are fixed: opcode bits 31:26, first source 25:21, second source 20:16, register-format destination 15:11, shift amount 10:6, function code 5:0, immediate 15:0. Opcode 0 with function 32 writes first+second source values to the destination in bits 15:11 (0x012A4020 writes to index 8).
- R2: Opcode 0 with function 33 (wrapping add) or 35 (wrapping subtract, first minus second) returns the 32-bit wrapped result and never raises overflow.
- R3: Signed add (opcode 0, function 32) raises ovf_o on two's-complement overflow; then wb_en_o is low while wb_data_o carries the wrapped sum.
- R4: Opcode 8 adds the sign-extended immediate to the first source value, writes to the index in bits 20:16 and raises ovf_o on signed overflow with wb_en_o low (0x22D5FFCE with first source 100 writes 50 to index 21).
- R5: Opcode 9 adds the sign-extended immediate, wraps, and never raises overflow.
- R6: Opcode 10 writes 1 if the first source value is signed-less-than the sign-extended immediate, else 0.
- R7: Opcode 11 sign-extends the immediate, then writes 1 if the first source value is unsigned-less-than it, else 0.
- R8: Opcode 13 ORs the first source value with the zero-extended immediate.
- R9: Opcode 15 writes the immediate into bits 31:16 with bits 15:0 cleared; opcode 15 then opcode 13 builds any 32-bit constant (0xABAB then 0xCDCD gives 0xABABCDCD).
- R10: When the destination index is 0, wb_en_o is low; the result is still computed.
- R11: Any other opcode, any other function code under opcode 0, or a non-zero shift amount under opcode 0 sets illegal_o, clears wb_en_o and ovf_o and drives wb_data_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of register at bits 25:21 |
| rt_val_i | input | 32 | Value of register at bits 20:16 |
| wb_data_o | output | 32 | Result to write back |
| wb_idx_o | output | 5 | Destination register index |
| wb_en_o | output | 1 | Write strobe for the destination |
| ovf_o | output | 1 | Signed overflow on add or add immediate |
| illegal_o | output | 1 | Unrecognised encoding |

## Verification
The bench uses the default parameters: 32-bit data, 5-bit register indices and a 16-bit immediate. At these values the signed boundaries 0x7FFFFFFF and 0x80000000 are reached directly. Immediates with bit 15 set show whether extension is sign or zero, and the unsigned compare against a sign-extended 0xFFFF separates it from the signed compare.

// File: rtl/dx_pkg.sv
package dx_pkg;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FUNCT_W = 6;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OP_ADDIU = 6'd9;
  localparam logic [OPC_W-1:0] OP_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OP_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OP_LUI   = 6'd15;

  localparam logic [FUNCT_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FUNCT_W-1:0] FN_ADDU = 6'd33;
  localparam logic [FUNCT_W-1:0] FN_SUBU = 6'd35;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_SLTU, ALU_OR, ALU_PASS
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SIGN, IMM_ZERO, IMM_UPPER
  } imm_kind_e;

  typedef struct packed {
    logic      legal;
    logic      use_imm;
    logic      dest_rd;
    logic      trap_ovf;
    alu_op_e   op;
    imm_kind_e imm_kind;
  } ctrl_t;
endpackage

// File: rtl/dx_ctrl.sv
module dx_ctrl
  import dx_pkg::*;
(
  input  logic [OPC_W-1:0]   opc_i,
  input  logic [FUNCT_W-1:0] funct_i,
  input  logic               shamt_zero_i,
  output ctrl_t              ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (opc_i)
      OP_RTYPE: begin
        if (shamt_zero_i) begin
          case (funct_i)
            FN_ADD: begin
              ctrl_o.legal = 1'b1; ctrl_o.dest_rd = 1'b1;
              ctrl_o.trap_ovf = 1'b1; ctrl_o.op = ALU_ADD;
            end
            FN_ADDU: begin
              ctrl_o.legal = 1'b1; ctrl_o.dest_rd = 1'b1;
              ctrl_o.op = ALU_ADD;
            end
            FN_SUBU: begin
              ctrl_o.legal = 1'b1; ctrl_o.dest_rd = 1'b1;
              ctrl_o.op = ALU_SUB;
            end
            default: ctrl_o = '0;
          endcase
        end
      end
      OP_ADDI: begin
        ctrl_o.legal = 1'b1; ctrl_o.use_imm = 1'b1; ctrl_o.trap_ovf = 1'b1;
        ctrl_o.op = ALU_ADD; ctrl_o.imm_kind = IMM_SIGN;
      end
      OP_ADDIU: begin
        ctrl_o.legal = 1'b1; ctrl_o.use_imm = 1'b1;
        ctrl_o.op = ALU_ADD; ctrl_o.imm_kind = IMM_SIGN;
      end
      OP_SLTI: begin
        ctrl_o.legal = 1'b1; ctrl_o.use_imm = 1'b1;
        ctrl_o.op = ALU_SLT; ctrl_o.imm_kind = IMM_SIGN;
      end
      OP_SLTIU: begin
        // sign-extend first, compare unsigned afterwards
        ctrl_o.legal = 1'b1; ctrl_o.use_imm = 1'b1;
        ctrl_o.op = ALU_SLTU; ctrl_o.imm_kind = IMM_SIGN;
      end
      OP_ORI: begin
        ctrl_o.legal = 1'b1; ctrl_o.use_imm = 1'b1;
        ctrl_o.op = ALU_OR; ctrl_o.imm_kind = IMM_ZERO;
      end
      OP_LUI: begin
        ctrl_o.legal = 1'b1; ctrl_o.use_imm = 1'b1;
        ctrl_o.op = ALU_PASS; ctrl_o.imm_kind = IMM_UPPER;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/dx_imm_ext.sv
module dx_imm_ext
  import dx_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  input  imm_kind_e        kind_i,
  output logic [XLEN-1:0]  ext_o
);
  localparam int unsigned PAD_W = XLEN - IMM_W;

  always_comb begin
    case (kind_i)
      IMM_SIGN:  ext_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
      IMM_ZERO:  ext_o = {{PAD_W{1'b0}}, imm_i};
      IMM_UPPER: ext_o = {imm_i, {PAD_W{1'b0}}};
      default:   ext_o = '0;
    endcase
  end
endmodule

// File: rtl/dx_alu.sv
module dx_alu
  import dx_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  alu_op_e         op_i,
  output logic [XLEN-1:0] res_o,
  output logic            add_ovf_o
);
  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN-1:0] sum, diff;
  logic            lt_s, lt_u;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign lt_u = a_i < b_i;
  assign lt_s = $signed(a_i) < $signed(b_i);

  // operands agree in sign, sum does not
  assign add_ovf_o = (op_i == ALU_ADD) && (a_i[MSB] == b_i[MSB]) && (sum[MSB] != a_i[MSB]);

  always_comb begin
    case (op_i)
      ALU_ADD:  res_o = sum;
      ALU_SUB:  res_o = diff;
      ALU_SLT:  res_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU: res_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_OR:   res_o = a_i | b_i;
      ALU_PASS: res_o = b_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/dx_exec_unit.sv
module dx_exec_unit
  import dx_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned REG_IDX_W = 5,
  parameter int unsigned IMM_W     = 16
) (
  input  logic [XLEN-1:0]      instr_i,
  input  logic [XLEN-1:0]      rs_val_i,
  input  logic [XLEN-1:0]      rt_val_i,
  output logic [XLEN-1:0]      wb_data_o,
  output logic [REG_IDX_W-1:0] wb_idx_o,
  output logic                 wb_en_o,
  output logic                 ovf_o,
  output logic                 illegal_o
);
  localparam int unsigned OPC_LSB = XLEN - OPC_W;
  localparam int unsigned RT_LSB  = OPC_LSB - 2*REG_IDX_W;
  localparam int unsigned RD_LSB  = RT_LSB - REG_IDX_W;
  localparam int unsigned SH_W    = RD_LSB - FUNCT_W;

  logic [OPC_W-1:0]     opc;
  logic [REG_IDX_W-1:0] rt_idx, rd_idx;
  logic [SH_W-1:0]      shamt;
  logic [FUNCT_W-1:0]   funct;
  logic [IMM_W-1:0]     imm;
  ctrl_t                ctrl;
  logic [XLEN-1:0]      imm_ext, opnd_b, alu_res;
  logic                 alu_ovf, ovf_hit;

  assign opc    = instr_i[XLEN-1:OPC_LSB];
  assign rt_idx = instr_i[RT_LSB+REG_IDX_W-1:RT_LSB];
  assign rd_idx = instr_i[RD_LSB+REG_IDX_W-1:RD_LSB];
  assign shamt  = instr_i[RD_LSB-1:FUNCT_W];
  assign funct  = instr_i[FUNCT_W-1:0];
  assign imm    = instr_i[IMM_W-1:0];

  dx_ctrl u_ctrl (
    .opc_i        (opc),
    .funct_i      (funct),
    .shamt_zero_i (shamt == '0),
    .ctrl_o       (ctrl)
  );

  dx_imm_ext #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
    .imm_i  (imm),
    .kind_i (ctrl.imm_kind),
    .ext_o  (imm_ext)
  );

  assign opnd_b = ctrl.use_imm ? imm_ext : rt_val_i;

  dx_alu #(.XLEN(XLEN)) u_alu (
    .a_i       (rs_val_i),
    .b_i       (opnd_b),
    .op_i      (ctrl.op),
    .res_o     (alu_res),
    .add_ovf_o (alu_ovf)
  );

  assign ovf_hit   = ctrl.legal & ctrl.trap_ovf & alu_ovf;
  assign wb_idx_o  = ctrl.dest_rd ? rd_idx : rt_idx;
  assign wb_data_o = ctrl.legal ? alu_res : '0;
  assign ovf_o     = ovf_hit;
  assign illegal_o = ~ctrl.legal;
  assign wb_en_o   = ctrl.legal & ~ovf_hit & (wb_idx_o != '0);
endmodule

// File: rtl/dx_exec_unit_chk.sv
module dx_exec_unit_chk (
  input logic [31:0] instr_i,
  input logic [31:0] wb_data_o,
  input logic [4:0]  wb_idx_o,
  input logic        wb_en_o,
  input logic        ovf_o,
  input logic        illegal_o
);
  logic [5:0] opc;
  logic [5:0] fn;
  assign opc = instr_i[31:26];
  assign fn  = instr_i[5:0];

  always_comb begin
    p_illegal_quiet_r11: assert (!illegal_o || (!wb_en_o && !ovf_o && wb_data_o == '0))
      else $error("illegal encoding wrote or flagged overflow");
    p_zero_dest_r10: assert (!wb_en_o || wb_idx_o != '0)
      else $error("write enabled to register 0");
    p_ovf_blocks_r3: assert (!ovf_o || !wb_en_o)
      else $error("write enabled on overflow");
    p_no_overflow_r2: assert (!ovf_o || opc == 6'd8 || (opc == 6'd0 && fn == 6'd32))
      else $error("overflow from a non-trapping operation");
    p_lui_shape_r9: assert (opc != 6'd15 || wb_data_o == {instr_i[15:0], 16'h0})
      else $error("load-upper result malformed");
    p_slt_bool_r6: assert (!(opc == 6'd10 || opc == 6'd11) || wb_data_o[31:1] == '0)
      else $error("set-less-than result not 0/1");
    p_dest_sel_r1: assert (illegal_o || wb_idx_o == (opc == 6'd0 ? instr_i[15:11] : instr_i[20:16]))
      else $error("destination field mis-selected");
  end
endmodule

bind dx_exec_unit dx_exec_unit_chk u_chk (
  .instr_i   (instr_i),
  .wb_data_o (wb_data_o),
  .wb_idx_o  (wb_idx_o),
  .wb_en_o   (wb_en_o),
  .ovf_o     (ovf_o),
  .illegal_o (illegal_o)
);

// File: tb/dx_exec_unit_test.sv
module dx_exec_unit_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] instr, rs_val, rt_val, wb_data;
  logic [4:0]  wb_idx;
  logic        wb_en, ovf, ill;

  dx_exec_unit uut (
    .instr_i(instr), .rs_val_i(rs_val), .rt_val_i(rt_val),
    .wb_data_o(wb_data), .wb_idx_o(wb_idx), .wb_en_o(wb_en),
    .ovf_o(ovf), .illegal_o(ill)
  );

  typedef struct {
    logic [31:0] instr;
    logic [31:0] data;
    logic [4:0]  idx;
    logic        en;
    logic        ovf;
    logic        ill;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                        input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] d, input logic [4:0] idx, input logic en,
                       input logic o, input logic il, input string req);
    exp_t e;
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b;
    e.instr = ins; e.data = d; e.idx = idx; e.en = en; e.ovf = o; e.ill = il; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: outputs settled half a cycle after the driver's edge
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if (wb_data !== e.data || wb_en !== e.en || ovf !== e.ovf || ill !== e.ill ||
          (!e.ill && wb_idx !== e.idx)) begin
        n_bad++;
        $display("FAIL %s instr=%h got data=%h idx=%0d en=%b ovf=%b ill=%b exp data=%h idx=%0d en=%b ovf=%b ill=%b",
                 e.req, e.instr, wb_data, wb_idx, wb_en, ovf, ill,
                 e.data, e.idx, e.en, e.ovf, e.ill);
      end
    end
  end

  initial begin
    instr = 32'h0; rs_val = 32'd5; rt_val = 32'd7;
    // reset state: all-zero word is unrecognised (R11)
    drive(32'h0, 32'd5, 32'd7, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, "R11 reset");
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1 register add, encoding check
    drive(32'h012A4020, 32'd100, 32'd23, 32'd123, 5'd8, 1'b1, 1'b0, 1'b0, "R1");
    drive(enc_r(5'd3, 5'd4, 5'd31, 6'd32), 32'hFFFF_FFFF, 32'd1, 32'h0, 5'd31, 1'b1, 1'b0, 1'b0, "R1");
    // R2 wrapping add/sub
    drive(enc_r(5'd1, 5'd2, 5'd9, 6'd33), 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 5'd9, 1'b1, 1'b0, 1'b0, "R2");
    drive(enc_r(5'd1, 5'd2, 5'd10, 6'd35), 32'd3, 32'd5, 32'hFFFF_FFFE, 5'd10, 1'b1, 1'b0, 1'b0, "R2");
    drive(enc_r(5'd1, 5'd2, 5'd10, 6'd35), 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 5'd10, 1'b1, 1'b0, 1'b0, "R2");
    // R3 signed overflow
    drive(enc_r(5'd1, 5'd2, 5'd11, 6'd32), 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 5'd11, 1'b0, 1'b1, 1'b0, "R3");
    drive(enc_r(5'd1, 5'd2, 5'd11, 6'd32), 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 5'd11, 1'b0, 1'b1, 1'b0, "R3");
    // R4 add immediate
    drive(32'h22D5FFCE, 32'd100, 32'd999, 32'd50, 5'd21, 1'b1, 1'b0, 1'b0, "R4");
    drive(enc_i(6'd8, 5'd1, 5'd7, 16'h7FFF), 32'h7FFF_FFF0, 32'd0, 32'h8000_7FEF, 5'd7, 1'b0, 1'b1, 1'b0, "R4");
    // R5 wrapping add immediate still sign-extends
    drive(enc_i(6'd9, 5'd1, 5'd7, 16'h0001), 32'h7FFF_FFFF, 32'd0, 32'h8000_0000, 5'd7, 1'b1, 1'b0, 1'b0, "R5");
    drive(enc_i(6'd9, 5'd1, 5'd7, 16'hFFFF), 32'd10, 32'd0, 32'd9, 5'd7, 1'b1, 1'b0, 1'b0, "R5");
    // R6 signed compare
    drive(enc_i(6'd10, 5'd1, 5'd12, 16'd3), 32'hFFFF_FFFB, 32'd0, 32'd1, 5'd12, 1'b1, 1'b0, 1'b0, "R6");
    drive(enc_i(6'd10, 5'd1, 5'd12, 16'hFFFF), 32'd5, 32'd0, 32'd0, 5'd12, 1'b1, 1'b0, 1'b0, "R6");
    // R7 unsigned compare after sign extension
    drive(enc_i(6'd11, 5'd1, 5'd13, 16'hFFFF), 32'd5, 32'd0, 32'd1, 5'd13, 1'b1, 1'b0, 1'b0, "R7");
    drive(enc_i(6'd11, 5'd1, 5'd13, 16'd3), 32'hFFFF_FFFB, 32'd0, 32'd0, 5'd13, 1'b1, 1'b0, 1'b0, "R7");
    drive(enc_i(6'd11, 5'd1, 5'd13, 16'h8000), 32'h0001_0000, 32'd0, 32'd1, 5'd13, 1'b1, 1'b0, 1'b0, "R7");
    // R8 OR immediate zero-extends
    drive(enc_i(6'd13, 5'd1, 5'd14, 16'h8001), 32'h1234_0000, 32'd0, 32'h1234_8001, 5'd14, 1'b1, 1'b0, 1'b0, "R8");
    // R9 load upper, then build a constant
    drive(enc_i(6'd15, 5'd1, 5'd8, 16'hABAB), 32'h5555_5555, 32'd0, 32'hABAB_0000, 5'd8, 1'b1, 1'b0, 1'b0, "R9");
    drive(enc_i(6'd13, 5'd8, 5'd8, 16'hCDCD), 32'hABAB_0000, 32'd0, 32'hABAB_CDCD, 5'd8, 1'b1, 1'b0, 1'b0, "R9");
    // R10 register 0 never written
    drive(enc_r(5'd1, 5'd2, 5'd0, 6'd33), 32'd4, 32'd5, 32'd9, 5'd0, 1'b0, 1'b0, 1'b0, "R10");
    drive(enc_i(6'd9, 5'd1, 5'd0, 16'd1), 32'd4, 32'd0, 32'd5, 5'd0, 1'b0, 1'b0, 1'b0, "R10");
    // R11 unrecognised encodings
    drive(enc_i(6'd4, 5'd1, 5'd2, 16'd3), 32'd1, 32'd1, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, "R11");
    drive(enc_r(5'd1, 5'd2, 5'd3, 6'd34), 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, "R11");
    drive(enc_i(6'd35, 5'd1, 5'd2, 16'd0), 32'd1, 32'd1, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, "R11");
    drive(32'h0022_1860, 32'h7FFF_FFFF, 32'd1, 32'h0, 5'd0, 1'b0, 1'b0, 1'b1, "R11 shamt");

    wait (exp_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got pending=%0d exp pending=0", exp_q.size());
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule